// File: doc/BRIEF.md
# Windowed Watchdog Timer with Prescaler

The block is a down-counting watchdog. A selectable prescaler divides its clock, which is a slow clock of its own. A set of option inputs is captured while reset is held. These options fix how the watchdog behaves until the next reset: whether it counts from reset or waits for software, the timeout length, the divide ratio, the bounds of the refresh window, where a fault is sent, and whether counting pauses while the system sleeps.

Software keeps the watchdog alive by writing a two-step refresh code. The refresh is accepted only while the counter lies inside a window whose edges are quarter fractions of the timeout period. An accepted refresh reloads the counter. A refresh outside the window is a fault, and so is running past zero. A fault goes either to a latched non-maskable interrupt line or to a one-cycle reset pulse. A small read port shows the live count, the run state and two sticky status bits.

Top module: `winwdt_top`

## Requirements
- R1: The option inputs are captured on every clock edge where `rst_n` is low. After reset they have no effect: changing them changes neither the reload value, the count rate nor the fault routing.
- R2: `opt_halt_i`=0 makes the watchdog count from the first edge after reset. `opt_halt_i`=1 keeps it halted with a frozen count until a `sw_start_i` pulse, which sets `running_o` and reloads the counter. `sw_start_i` has no effect while running.
- R3: The timeout code `opt_tmo_i` selects the reload value: 0 gives 127, 1 gives 511, 2 gives 1023 and 3 gives 2047. The count equals the reload value after reset.
- R4: The divide code `opt_div_i` selects one tick per 1, 16, 32, 64, 256 or 128 clocks for codes 0, 2, 3, 4, 5 and 15. Any other code behaves as /128. The first tick after a reload falls on the N-th clock edge.
- R5: Each tick decrements the count. A tick at count 0 is an underflow: it sets `sts_uflow_o` and reloads the counter. With a /1 prescaler the underflow comes on edge reload+1.
- R6: A refresh is a write of 0x00 followed, on the next write (idle cycles allowed), by 0xFF. Any other value breaks the sequence. 0xFF without a preceding 0x00 does nothing. A refresh while halted has no effect.
- R7: With period T = reload+1 and Q = T/4, a refresh is inside the window when (3-wend)*Q <= count < (wstart+1)*Q. The count is taken on the edge of the 0xFF write. An accepted refresh reloads the counter and clears the prescaler. Codes 3/3 leave the window unrestricted.
- R8: A refresh outside the window sets `sts_referr_o`, counts as a fault and reloads the counter. A window whose opening lies below its closing is empty, so every refresh is a fault.
- R9: With `opt_fault_rst_i`=0, a fault raises `wdt_nmi_o` on the following edge and `wdt_rst_o` stays low. With 1, `wdt_rst_o` pulses high for exactly one cycle after the faulting edge and `wdt_nmi_o` never rises.
- R10: `wdt_nmi_o` stays high until `sw_clr_i` clears both status bits. A fault on the same edge as a clear wins.
- R11: With `opt_sleep_stop_i`=1 the count and prescaler hold while `sleep_i` is high and resume when it falls. With 0, `sleep_i` has no effect.
- R12: Reset clears `sts_uflow_o`, `sts_referr_o`, `wdt_nmi_o` and `wdt_rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Synchronous active-low reset; options captured while low |
| opt_halt_i | input | 1 | 0: count from reset, 1: wait for start |
| opt_tmo_i | input | 2 | Timeout code |
| opt_div_i | input | 4 | Prescaler divide code |
| opt_wstart_i | input | 2 | Window opening code |
| opt_wend_i | input | 2 | Window closing code |
| opt_fault_rst_i | input | 1 | 0: fault to NMI, 1: fault to reset pulse |
| opt_sleep_stop_i | input | 1 | 1: hold count during sleep |
| sw_wr_i | input | 1 | Refresh register write strobe |
| sw_data_i | input | DATA_W | Refresh write data |
| sw_start_i | input | 1 | Start pulse from software |
| sw_clr_i | input | 1 | Clear status bits |
| sleep_i | input | 1 | Low-power mode indication |
| cnt_o | output | CNT_W | Current count |
| running_o | output | 1 | Counter active |
| sts_uflow_o | output | 1 | Sticky underflow status |
| sts_referr_o | output | 1 | Sticky refresh-error status |
| wdt_nmi_o | output | 1 | Non-maskable interrupt request (level) |
| wdt_rst_o | output | 1 | Reset request (one-cycle pulse) |

## Verification
The bound checker watches several rules on every cycle. An underflow or an accepted refresh leaves the count at the reload value one edge later. A refused refresh raises its status bit. A halted counter and a sleep-frozen counter hold still. The NMI line stays up until cleared and never rises in reset mode. The exact timing needs the bench's scenarios. That covers the reload value for each timeout code, the tick spacing for each divide code, and the window bounds at counts on either side. It also covers the two-step write sequence and the proof that options changed after reset are ignored.

// File: rtl/winwdt_pkg.sv
package winwdt_pkg;

  typedef struct packed {
    logic [1:0] tmo;
    logic [3:0] div;
    logic [1:0] wstart;
    logic [1:0] wend;
    logic       fault_rst;
    logic       sleep_stop;
  } wdt_cfg_t;

  // Reload value: (128 << shift) - 1, shift = 0,2,3,4 for codes 0..3
  function automatic logic [15:0] reload_of(input logic [1:0] code);
    logic [2:0] sh;
    sh = (code == 2'd0) ? 3'd0 : ({1'b0, code} + 3'd1);
    return (16'd128 << sh) - 16'd1;
  endfunction

  // Prescaler ratio as a power of two; unknown codes fall back to /128
  function automatic logic [3:0] div_shift(input logic [3:0] code);
    logic [3:0] s;
    case (code)
      4'd0:    s = 4'd0;
      4'd2:    s = 4'd4;
      4'd3:    s = 4'd5;
      4'd4:    s = 4'd6;
      4'd5:    s = 4'd8;
      default: s = 4'd7;
    endcase
    return s;
  endfunction

  // Window test: closing bound <= count < opening bound, in quarters of T
  function automatic logic win_open(input logic [15:0] cnt, input logic [15:0] rld,
                                    input logic [1:0] sc, input logic [1:0] ec);
    logic [17:0] q;
    logic [17:0] sb;
    logic [17:0] eb;
    q  = ({2'b0, rld} + 18'd1) >> 2;
    sb = q * ({16'b0, sc} + 18'd1);
    eb = q * (18'd3 - {16'b0, ec});
    return ({2'b0, cnt} < sb) && ({2'b0, cnt} >= eb);
  endfunction

endpackage

// File: rtl/winwdt_cfg.sv
module winwdt_cfg
  import winwdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  wdt_cfg_t opt_i,
  output wdt_cfg_t cfg_o
);
  // Options follow the inputs only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) cfg_o <= opt_i;
  end
endmodule

// File: rtl/winwdt_prescale.sv
module winwdt_prescale #(
  parameter int PRE_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic [3:0] shift_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask   = ~({PRE_W{1'b1}} << shift_i);
    tick_o = en_i && (pre_q == mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i)  pre_q <= '0;
    else if (en_i)        pre_q <= tick_o ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/winwdt_kick.sv
module winwdt_kick #(
  parameter int              DW       = 8,
  parameter logic [DW-1:0]   ARM_VAL  = '0,
  parameter logic [DW-1:0]   FIRE_VAL = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  output logic          kick_o
);
  logic armed_q;

  assign kick_o = wr_i && armed_q && (data_i == FIRE_VAL);

  always_ff @(posedge clk) begin
    if (!rst_n)    armed_q <= 1'b0;
    else if (wr_i) armed_q <= (data_i == ARM_VAL);
  end
endmodule

// File: rtl/winwdt_fault.sv
module winwdt_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_rst_i,
  input  logic uflow_evt_i,
  input  logic referr_evt_i,
  input  logic clr_i,
  output logic sts_uflow_o,
  output logic sts_referr_o,
  output logic nmi_o,
  output logic rst_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_uflow_o  <= 1'b0;
      sts_referr_o <= 1'b0;
      rst_o        <= 1'b0;
    end else begin
      sts_uflow_o  <= uflow_evt_i  | (sts_uflow_o  & ~clr_i);
      sts_referr_o <= referr_evt_i | (sts_referr_o & ~clr_i);
      rst_o        <= fault_rst_i & (uflow_evt_i | referr_evt_i);
    end
  end

  assign nmi_o = ~fault_rst_i & (sts_uflow_o | sts_referr_o);
endmodule

// File: rtl/winwdt_top.sv
module winwdt_top
  import winwdt_pkg::*;
#(
  parameter int CNT_W  = 11,
  parameter int PRE_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opt_halt_i,
  input  logic [1:0]        opt_tmo_i,
  input  logic [3:0]        opt_div_i,
  input  logic [1:0]        opt_wstart_i,
  input  logic [1:0]        opt_wend_i,
  input  logic              opt_fault_rst_i,
  input  logic              opt_sleep_stop_i,
  input  logic              sw_wr_i,
  input  logic [DATA_W-1:0] sw_data_i,
  input  logic              sw_start_i,
  input  logic              sw_clr_i,
  input  logic              sleep_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              running_o,
  output logic              sts_uflow_o,
  output logic              sts_referr_o,
  output logic              wdt_nmi_o,
  output logic              wdt_rst_o
);
  wdt_cfg_t opt_w;
  wdt_cfg_t cfg_q;

  logic [CNT_W-1:0] cnt_q;
  logic             running_q;
  logic [CNT_W-1:0] reload_c;
  logic [CNT_W-1:0] reload_rst;

  // named internal events
  logic count_en;
  logic tick;
  logic kick_raw;
  logic kick_evt;
  logic in_win;
  logic kick_ok;
  logic referr_evt;
  logic uflow_evt;
  logic start_evt;
  logic reload_evt;
  logic cfg_fault_rst;
  logic cfg_sleep_stop;

  always_comb begin
    opt_w.tmo        = opt_tmo_i;
    opt_w.div        = opt_div_i;
    opt_w.wstart     = opt_wstart_i;
    opt_w.wend       = opt_wend_i;
    opt_w.fault_rst  = opt_fault_rst_i;
    opt_w.sleep_stop = opt_sleep_stop_i;
  end

  winwdt_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .opt_i (opt_w),
    .cfg_o (cfg_q)
  );

  assign cfg_fault_rst  = cfg_q.fault_rst;
  assign cfg_sleep_stop = cfg_q.sleep_stop;

  always_comb begin
    reload_c   = CNT_W'(reload_of(cfg_q.tmo));
    reload_rst = CNT_W'(reload_of(opt_tmo_i));
    count_en   = running_q && !(cfg_sleep_stop && sleep_i);
    in_win     = win_open(16'(cnt_q), 16'(reload_c), cfg_q.wstart, cfg_q.wend);
    kick_evt   = kick_raw && running_q;
    kick_ok    = kick_evt && in_win;
    referr_evt = kick_evt && !in_win;
    uflow_evt  = tick && (cnt_q == '0);
    start_evt  = sw_start_i && !running_q;
    reload_evt = start_evt || kick_evt || uflow_evt;
  end

  winwdt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (reload_evt),
    .en_i    (count_en),
    .shift_i (div_shift(cfg_q.div)),
    .tick_o  (tick)
  );

  winwdt_kick #(
    .DW       (DATA_W),
    .ARM_VAL  ({DATA_W{1'b0}}),
    .FIRE_VAL ({DATA_W{1'b1}})
  ) u_kick (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (sw_wr_i),
    .data_i (sw_data_i),
    .kick_o (kick_raw)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= reload_rst;
      running_q <= !opt_halt_i;
    end else if (reload_evt) begin
      cnt_q     <= reload_c;
      running_q <= 1'b1;
    end else if (tick) begin
      cnt_q     <= cnt_q - 1'b1;
    end
  end

  winwdt_fault u_fault (
    .clk          (clk),
    .rst_n        (rst_n),
    .fault_rst_i  (cfg_fault_rst),
    .uflow_evt_i  (uflow_evt),
    .referr_evt_i (referr_evt),
    .clr_i        (sw_clr_i),
    .sts_uflow_o  (sts_uflow_o),
    .sts_referr_o (sts_referr_o),
    .nmi_o        (wdt_nmi_o),
    .rst_o        (wdt_rst_o)
  );

  assign cnt_o     = cnt_q;
  assign running_o = running_q;
endmodule

// File: rtl/winwdt_chk.sv
module winwdt_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_start_i,
  input logic             sw_clr_i,
  input logic             sleep_i,
  input logic             sleep_stop,
  input logic             fault_rst,
  input logic             running,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload,
  input logic             kick_evt,
  input logic             kick_ok,
  input logic             uflow_evt,
  input logic             referr_evt,
  input logic             sts_uflow,
  input logic             sts_referr,
  input logic             nmi
);
  // R5
  uflow_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_evt |=> (sts_uflow && cnt == reload));

  // R7
  kick_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_ok |=> (cnt == reload));

  // R8
  referr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    referr_evt |=> sts_referr);

  // R2
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !sw_start_i) |=> ($stable(cnt) && !running));

  // R11
  sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && sleep_stop && sleep_i && !kick_evt) |=> $stable(cnt));

  // R10
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi && !sw_clr_i) |=> nmi);

  // R9
  nmi_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow_evt && !fault_rst) |=> nmi);

  // R9
  nmi_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_rst |-> !nmi);
endmodule

bind winwdt_top winwdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_start_i (sw_start_i),
  .sw_clr_i   (sw_clr_i),
  .sleep_i    (sleep_i),
  .sleep_stop (cfg_sleep_stop),
  .fault_rst  (cfg_fault_rst),
  .running    (running_q),
  .cnt        (cnt_q),
  .reload     (reload_c),
  .kick_evt   (kick_evt),
  .kick_ok    (kick_ok),
  .uflow_evt  (uflow_evt),
  .referr_evt (referr_evt),
  .sts_uflow  (sts_uflow_o),
  .sts_referr (sts_referr_o),
  .nmi        (wdt_nmi_o)
);

// File: tb/tb_winwdt_top.sv
module tb_winwdt_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opt_halt = 1'b0;
  logic [1:0]  opt_tmo = 2'd0;
  logic [3:0]  opt_div = 4'd0;
  logic [1:0]  opt_ws = 2'd3;
  logic [1:0]  opt_we = 2'd3;
  logic        opt_frst = 1'b0;
  logic        opt_ss = 1'b0;
  logic        sw_wr = 1'b0;
  logic [7:0]  sw_data = 8'd0;
  logic        sw_start = 1'b0;
  logic        sw_clr = 1'b0;
  logic        sleep = 1'b0;
  logic [10:0] cnt;
  logic        running;
  logic        sts_uflow;
  logic        sts_referr;
  logic        nmi;
  logic        rstp;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  winwdt_top dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .opt_halt_i       (opt_halt),
    .opt_tmo_i        (opt_tmo),
    .opt_div_i        (opt_div),
    .opt_wstart_i     (opt_ws),
    .opt_wend_i       (opt_we),
    .opt_fault_rst_i  (opt_frst),
    .opt_sleep_stop_i (opt_ss),
    .sw_wr_i          (sw_wr),
    .sw_data_i        (sw_data),
    .sw_start_i       (sw_start),
    .sw_clr_i         (sw_clr),
    .sleep_i          (sleep),
    .cnt_o            (cnt),
    .running_o        (running),
    .sts_uflow_o      (sts_uflow),
    .sts_referr_o     (sts_referr),
    .wdt_nmi_o        (nmi),
    .wdt_rst_o        (rstp)
  );

  // {tmo, div, edges, expected count}
  localparam logic [29:0] VECS [7] = '{
    {2'd0, 4'd0,  12'd10,  12'd117},
    {2'd1, 4'd2,  12'd100, 12'd505},
    {2'd2, 4'd3,  12'd100, 12'd1020},
    {2'd3, 4'd4,  12'd200, 12'd2044},
    {2'd3, 4'd15, 12'd300, 12'd2045},
    {2'd1, 4'd5,  12'd600, 12'd509},
    {2'd0, 4'd7,  12'd300, 12'd125}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic halt, input logic [1:0] tmo, input logic [3:0] dv,
                          input logic [1:0] ws, input logic [1:0] we,
                          input logic frst, input logic ss);
    @(negedge clk);
    rst_n = 1'b0; opt_halt = halt; opt_tmo = tmo; opt_div = dv;
    opt_ws = ws; opt_we = we; opt_frst = frst; opt_ss = ss;
    sw_wr = 1'b0; sw_data = 8'd0; sw_start = 1'b0; sw_clr = 1'b0; sleep = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    sw_wr = 1'b1; sw_data = d;
    @(negedge clk);
    sw_wr = 1'b0;
  endtask

  task automatic run_table();
    for (int i = 0; i < 7; i++) begin
      logic [29:0] v;
      v = VECS[i];
      do_reset(1'b0, v[29:28], v[27:24], 2'd3, 2'd3, 1'b0, 1'b0);
      edges(int'(v[23:12]));
      // R3 R4: reload by timeout code, pace by divide code
      chk("R4", "count after prescaled run", int'(cnt), int'(v[11:0]));
    end
  endtask

  task automatic run_all();
    run_table();

    // R12 R2: halted start mode, reset state
    do_reset(1'b1, 2'd1, 4'd0, 2'd3, 2'd3, 1'b0, 1'b0);
    chk("R12", "uflow after reset", int'(sts_uflow), 0);
    chk("R12", "referr after reset", int'(sts_referr), 0);
    chk("R12", "nmi after reset", int'(nmi), 0);
    chk("R12", "rst after reset", int'(rstp), 0);
    chk("R2", "running when halted", int'(running), 0);
    chk("R3", "reset count code1", int'(cnt), 511);
    edges(20);
    chk("R2", "halted count frozen", int'(cnt), 511);
    wr(8'h00); wr(8'hFF);
    chk("R6", "refresh while halted referr", int'(sts_referr), 0);
    chk("R6", "refresh while halted count", int'(cnt), 511);
    sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
    chk("R2", "running after start", int'(running), 1);
    chk("R2", "count after start", int'(cnt), 511);
    edges(5);
    chk("R2", "count 5 after start", int'(cnt), 506);

    // R5 R9 R10: underflow routed to NMI; clear on the fault edge loses
    do_reset(1'b0, 2'd0, 4'd0, 2'd3, 2'd3, 1'b0, 1'b0);
    edges(127);
    chk("R5", "count before underflow", int'(cnt), 0);
    chk("R5", "no uflow yet", int'(sts_uflow), 0);
    sw_clr = 1'b1;
    edges(1);
    chk("R10", "uflow set wins over clear", int'(sts_uflow), 1);
    chk("R9", "nmi after underflow", int'(nmi), 1);
    chk("R9", "no reset pulse in nmi mode", int'(rstp), 0);
    chk("R5", "reload after underflow", int'(cnt), 127);
    edges(1);
    sw_clr = 1'b0;
    chk("R10", "uflow cleared", int'(sts_uflow), 0);
    chk("R10", "nmi cleared", int'(nmi), 0);

    // R9: underflow routed to reset pulse
    do_reset(1'b0, 2'd0, 4'd0, 2'd3, 2'd3, 1'b1, 1'b0);
    edges(127);
    chk("R9", "no pulse before underflow", int'(rstp), 0);
    edges(1);
    chk("R9", "reset pulse high", int'(rstp), 1);
    chk("R9", "nmi low in reset mode", int'(nmi), 0);
    chk("R5", "uflow status in reset mode", int'(sts_uflow), 1);
    edges(1);
    chk("R9", "reset pulse one cycle", int'(rstp), 0);

    // R6: broken and valid sequences, unrestricted window
    do_reset(1'b0, 2'd0, 4'd0, 2'd3, 2'd3, 1'b0, 1'b0);
    edges(10);
    wr(8'h00); wr(8'h12); wr(8'hFF);
    chk("R6", "broken sequence ignored", int'(cnt), 114);
    chk("R6", "broken sequence no fault", int'(sts_referr), 0);
    wr(8'h00); wr(8'hFF);
    chk("R6", "valid refresh reloads", int'(cnt), 127);
    chk("R7", "open window no fault", int'(sts_referr), 0);

    // R7: refresh inside window 32 <= count < 64
    do_reset(1'b0, 2'd0, 4'd0, 2'd1, 2'd2, 1'b0, 1'b0);
    edges(70);
    wr(8'h00); wr(8'hFF);
    chk("R7", "in-window refresh reload", int'(cnt), 127);
    chk("R7", "in-window refresh no error", int'(sts_referr), 0);
    edges(1);
    chk("R7", "count resumes after refresh", int'(cnt), 126);

    // R8: refresh too early for the same window
    do_reset(1'b0, 2'd0, 4'd0, 2'd1, 2'd2, 1'b0, 1'b0);
    edges(20);
    wr(8'h00); wr(8'hFF);
    chk("R8", "early refresh error", int'(sts_referr), 1);
    chk("R8", "early refresh nmi", int'(nmi), 1);
    chk("R8", "early refresh reload", int'(cnt), 127);

    // R8: empty window (opening 25 percent, closing 75 percent)
    do_reset(1'b0, 2'd0, 4'd0, 2'd0, 2'd0, 1'b0, 1'b0);
    edges(50);
    wr(8'h00); wr(8'hFF);
    chk("R8", "empty window error", int'(sts_referr), 1);

    // R11: sleep freezes with option set
    do_reset(1'b0, 2'd0, 4'd0, 2'd3, 2'd3, 1'b0, 1'b1);
    edges(10);
    sleep = 1'b1;
    edges(20);
    chk("R11", "frozen in sleep", int'(cnt), 117);
    sleep = 1'b0;
    edges(3);
    chk("R11", "resumes after sleep", int'(cnt), 114);

    // R11: sleep ignored with option clear
    do_reset(1'b0, 2'd0, 4'd0, 2'd3, 2'd3, 1'b0, 1'b0);
    edges(10);
    sleep = 1'b1;
    edges(20);
    sleep = 1'b0;
    chk("R11", "counts through sleep", int'(cnt), 97);

    // R1: options changed after reset have no effect
    do_reset(1'b0, 2'd0, 4'd0, 2'd3, 2'd3, 1'b0, 1'b0);
    opt_tmo = 2'd3; opt_div = 4'd15; opt_frst = 1'b1; opt_ss = 1'b1; sleep = 1'b1;
    edges(10);
    chk("R1", "pace unchanged", int'(cnt), 117);
    edges(118);
    chk("R1", "reload unchanged", int'(cnt), 127);
    chk("R1", "routing unchanged", int'(nmi), 1);
    sleep = 1'b0;
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule